// File: doc/BRIEF.md
# Dual-Scan LCD Refresh Timing Generator

This block keeps a dual-scan monochrome panel alive. Such a panel has no frame memory of its own, so it needs a continuous stream of pixel data and timing pulses, even when the image never changes. The panel is split into an upper half and a lower half. The block sends the same row index of both halves at once, on two 4-bit nibble buses. It shifts them in with a dot clock, latches each finished row with a row strobe, and marks the first row of every frame with a scan-start pulse. A polarity line flips once per frame, so that no net DC voltage builds up across the liquid crystal.

Pixel nibbles come from a synchronous framebuffer with two read ports, one for each half. Both addresses are issued in the same cycle, one cycle before the nibbles are needed. The framebuffer holds the upper half as rows `0..ROWS-1` and the lower half as rows `ROWS..2*ROWS-1`. Each row takes `NIB = DOTS/BUS_W` consecutive nibble addresses.

The panel cannot wait, so the read port has no back-pressure. There is no ready signal. Every request (`fb_rd` high) must be answered on the data inputs in the very next cycle. The block has no valid/ready stream anywhere. The output pins are plain timing signals that the panel samples.

Frame timing is built from three parameters:
- a dot-slot length of `CP2_DIV` clock cycles;
- a row-latch window of `LATCH_CYC` cycles;
- the clock rate `CLK_KHZ`.

Top module: `lcd_dualscan_ctrl`

## Requirements
- R1: While reset is held, the following outputs are all 0: `lcd_cp2`, `lcd_cp1`, `lcd_s`, `lcd_m`, `lcd_du` and `lcd_dl`.
- R2: Each row is sent as exactly NIB dot-clock pulses. Every slot lasts `CP2_DIV` cycles, and `lcd_cp2` is high for the first `CP2_DIV/2` of them. The data buses hold steady across the whole slot, including the falling edge of `lcd_cp2`, where the panel samples.
- R3: The nibble on `lcd_du` at the k-th dot-clock fall of row r is the upper word at address `r*NIB+k`. In the same slot, `lcd_dl` carries the lower word at address `(r+ROWS)*NIB+k`. Nibbles go left to right within a row, with bit 3 passed through unchanged.
- R4: After the last nibble of a row, `lcd_cp1` is high for `LATCH_CYC` cycles and `lcd_cp2` stays low throughout. The first dot pulse of the next row starts in the cycle right after `lcd_cp1` falls.
- R5: Rows go from 0 to ROWS-1, top to bottom, and then wrap back to row 0 with no gap, frame after frame.
- R6: `lcd_s` is high exactly during the `lcd_cp1` pulse that latches row 0, and never at any other time.
- R7: `lcd_m` toggles exactly once per frame, in the cycle right after the row ROWS-1 latch pulse ends. It starts at 0.
- R8: `fb_rd` is a single-cycle request with both addresses valid in that cycle. The returned nibbles are sampled at the following clock edge, and they appear on the buses at the start of the next slot. Addresses always stay below `2*ROWS*NIB`.
- R9: The frame period is `ROWS*(NIB*CP2_DIV+LATCH_CYC)` cycles. Elaboration rejects any parameter set whose frame at `CLK_KHZ` would be shorter than 8 ms. The defaults give about 12.44 ms at 12.5 MHz.
- R10: The first latch window after reset only primes the fetch of row 0. It makes no `lcd_cp1` or `lcd_s` pulse and does not toggle `lcd_m`, so the first row strobe rises `LATCH_CYC+NIB*CP2_DIV` cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_rd | output | 1 | Framebuffer read request, one cycle ahead of use |
| fb_addr_up | output | AW | Upper-half nibble address |
| fb_addr_lo | output | AW | Lower-half nibble address |
| fb_data_up | input | BUS_W | Upper nibble, valid the cycle after `fb_rd` |
| fb_data_lo | input | BUS_W | Lower nibble, valid the cycle after `fb_rd` |
| lcd_cp2 | output | 1 | Dot shift clock |
| lcd_cp1 | output | 1 | Row latch strobe |
| lcd_s | output | 1 | Scan start marker |
| lcd_m | output | 1 | Frame polarity |
| lcd_du | output | BUS_W | Upper-half nibble bus |
| lcd_dl | output | BUS_W | Lower-half nibble bus |

## Verification
Two functions share cycles at the end of every frame. The first is the row ROWS-1 latch pulse, which flips the polarity as it ends. The second is the row 0 prefetch, which is issued inside that same latch window and must land on the buses in time for the first dot pulse of the new frame. The bench uses a tiny panel (4 nibbles by 3 rows) so that this wrap happens every 33 cycles and recurs over several frames. A scoreboard compares every nibble pair at its dot-clock fall. Alongside it, the bench checks that the polarity edge lines up with the fall of the last row strobe, that exactly one polarity toggle falls between successive scan-start pulses, and that the frame period is correct.

// File: rtl/lcdtc_pkg.sv
package lcdtc_pkg;

  typedef enum logic {
    PH_SHIFT = 1'b0,
    PH_LATCH = 1'b1
  } line_phase_t;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lcdtc_timing.sv
module lcdtc_timing
  import lcdtc_pkg::*;
#(
  parameter int unsigned NIB    = 160,
  parameter int unsigned ROWS   = 240,
  parameter int unsigned DIV    = 4,
  parameter int unsigned LBLANK = 8,
  localparam int unsigned CW = bits_for(NIB),
  localparam int unsigned RW = bits_for(ROWS),
  localparam int unsigned SW = bits_for((DIV > LBLANK) ? DIV : LBLANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          cp2_o,
  output logic          cp1_o,
  output logic          s_o,
  output logic          m_o,
  output logic          fetch_req_o,
  output logic [RW-1:0] fetch_row_o,
  output logic [CW-1:0] fetch_col_o
);

  localparam logic [SW-1:0] SUB_SLOT_END  = SW'(DIV - 1);
  localparam logic [SW-1:0] SUB_SLOT_PRE  = SW'(DIV - 2);
  localparam logic [SW-1:0] SUB_LAT_END   = SW'(LBLANK - 1);
  localparam logic [SW-1:0] SUB_LAT_PRE   = SW'(LBLANK - 2);
  localparam logic [SW-1:0] SUB_CP2_HIGH  = SW'(DIV / 2);
  localparam logic [CW-1:0] COL_LAST      = CW'(NIB - 1);
  localparam logic [RW-1:0] ROW_LAST      = RW'(ROWS - 1);

  line_phase_t   phase;
  logic [SW-1:0] sub;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          priming;
  logic          pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_LATCH;
      sub     <= '0;
      col     <= '0;
      row     <= ROW_LAST;
      priming <= 1'b1;
      pol     <= 1'b0;
    end else begin
      unique case (phase)
        PH_SHIFT: begin
          if (sub == SUB_SLOT_END) begin
            sub <= '0;
            if (col == COL_LAST) begin
              col   <= '0;
              phase <= PH_LATCH;
            end else begin
              col <= col + 1'b1;
            end
          end else begin
            sub <= sub + 1'b1;
          end
        end
        PH_LATCH: begin
          if (sub == SUB_LAT_END) begin
            sub     <= '0;
            phase   <= PH_SHIFT;
            priming <= 1'b0;
            if (row == ROW_LAST) begin
              row <= '0;
              if (!priming) pol <= ~pol;
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: phase <= PH_LATCH;
      endcase
    end
  end

  always_comb begin
    cp2_o = (phase == PH_SHIFT) && (sub < SUB_CP2_HIGH);
    cp1_o = (phase == PH_LATCH) && !priming;
    s_o   = cp1_o && (row == '0);
    m_o   = pol;
    if (phase == PH_LATCH) begin
      fetch_req_o = (sub == SUB_LAT_PRE);
      fetch_row_o = (row == ROW_LAST) ? '0 : row + 1'b1;
      fetch_col_o = '0;
    end else begin
      fetch_req_o = (sub == SUB_SLOT_PRE) && (col != COL_LAST);
      fetch_row_o = row;
      fetch_col_o = col + 1'b1;
    end
  end

  assert_cp2_quiet_in_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cp1_o |-> !cp2_o);

  assert_shift_resumes_after_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cp1_o) |-> cp2_o);

  assert_start_within_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_o |-> cp1_o);

  assert_polarity_edge_after_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(m_o) |-> ($past(cp1_o) && !cp1_o));

endmodule

// File: rtl/lcdtc_fetch.sv
module lcdtc_fetch #(
  parameter int unsigned NIB   = 160,
  parameter int unsigned ROWS  = 240,
  parameter int unsigned BUS_W = 4,
  parameter int unsigned CW    = 8,
  parameter int unsigned RW    = 8,
  parameter int unsigned AW    = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [RW-1:0]    row_i,
  input  logic [CW-1:0]    col_i,
  input  logic             cp2_i,
  output logic             fb_rd_o,
  output logic [AW-1:0]    fb_addr_up_o,
  output logic [AW-1:0]    fb_addr_lo_o,
  input  logic [BUS_W-1:0] fb_data_up_i,
  input  logic [BUS_W-1:0] fb_data_lo_i,
  output logic [BUS_W-1:0] du_o,
  output logic [BUS_W-1:0] dl_o
);

  localparam logic [AW-1:0] HALF_WORDS = AW'(ROWS * NIB);
  localparam logic [AW-1:0] ROW_WORDS  = AW'(NIB);

  logic             req_q;
  logic [BUS_W-1:0] du_q;
  logic [BUS_W-1:0] dl_q;

  always_comb begin
    fb_rd_o      = req_i;
    fb_addr_up_o = AW'(row_i) * ROW_WORDS + AW'(col_i);
    fb_addr_lo_o = fb_addr_up_o + HALF_WORDS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      du_q  <= '0;
      dl_q  <= '0;
    end else begin
      req_q <= req_i;
      if (req_q) begin
        du_q <= fb_data_up_i;
        dl_q <= fb_data_lo_i;
      end
    end
  end

  assign du_o = du_q;
  assign dl_o = dl_q;

  assert_data_steady_at_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cp2_i) |-> ($stable(du_o) && $stable(dl_o)));

  assert_addr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_o |-> (fb_addr_lo_o < (HALF_WORDS + HALF_WORDS)));

endmodule

// File: rtl/lcd_dualscan_ctrl.sv
module lcd_dualscan_ctrl
  import lcdtc_pkg::*;
#(
  parameter int unsigned DOTS      = 640,
  parameter int unsigned BUS_W     = 4,
  parameter int unsigned ROWS      = 240,
  parameter int unsigned CP2_DIV   = 4,
  parameter int unsigned LATCH_CYC = 8,
  parameter int unsigned CLK_KHZ   = 12500,
  localparam int unsigned NIB = DOTS / BUS_W,
  localparam int unsigned AW  = bits_for(2 * ROWS * NIB)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             fb_rd,
  output logic [AW-1:0]    fb_addr_up,
  output logic [AW-1:0]    fb_addr_lo,
  input  logic [BUS_W-1:0] fb_data_up,
  input  logic [BUS_W-1:0] fb_data_lo,
  output logic             lcd_cp2,
  output logic             lcd_cp1,
  output logic             lcd_s,
  output logic             lcd_m,
  output logic [BUS_W-1:0] lcd_du,
  output logic [BUS_W-1:0] lcd_dl
);

  localparam int unsigned CW        = bits_for(NIB);
  localparam int unsigned RW        = bits_for(ROWS);
  localparam longint unsigned LINE_CYC  = NIB * CP2_DIV + LATCH_CYC;
  localparam longint unsigned FRAME_CYC = ROWS * LINE_CYC;
  localparam longint unsigned FRAME_US  = (FRAME_CYC * 1000) / CLK_KHZ;

  // R9: refuse parameter sets that would refresh faster than 125 Hz
  generate
    if (CP2_DIV < 2) begin : g_bad_div
      $error("dot slot must span at least two clock cycles");
    end
    if (LATCH_CYC < 2) begin : g_bad_latch
      $error("latch window must span at least two clock cycles");
    end
    if (NIB < 2 || ROWS < 2 || (DOTS % BUS_W) != 0) begin : g_bad_geom
      $error("row width must be a multiple of the bus and geometry at least 2x2");
    end
    if (FRAME_US < 8000) begin : g_bad_rate
      $error("frame period below 8 ms");
    end
  endgenerate

  logic          fetch_req;
  logic [RW-1:0] fetch_row;
  logic [CW-1:0] fetch_col;

  lcdtc_timing #(
    .NIB    (NIB),
    .ROWS   (ROWS),
    .DIV    (CP2_DIV),
    .LBLANK (LATCH_CYC)
  ) u_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .cp2_o       (lcd_cp2),
    .cp1_o       (lcd_cp1),
    .s_o         (lcd_s),
    .m_o         (lcd_m),
    .fetch_req_o (fetch_req),
    .fetch_row_o (fetch_row),
    .fetch_col_o (fetch_col)
  );

  lcdtc_fetch #(
    .NIB   (NIB),
    .ROWS  (ROWS),
    .BUS_W (BUS_W),
    .CW    (CW),
    .RW    (RW),
    .AW    (AW)
  ) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (fetch_req),
    .row_i        (fetch_row),
    .col_i        (fetch_col),
    .cp2_i        (lcd_cp2),
    .fb_rd_o      (fb_rd),
    .fb_addr_up_o (fb_addr_up),
    .fb_addr_lo_o (fb_addr_lo),
    .fb_data_up_i (fb_data_up),
    .fb_data_lo_i (fb_data_lo),
    .du_o         (lcd_du),
    .dl_o         (lcd_dl)
  );

endmodule

// File: tb/lcd_dualscan_ctrl_bench.sv
module lcd_dualscan_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DOTS  = 16;
  localparam int BUS_W = 4;
  localparam int ROWS  = 3;
  localparam int DIV   = 2;
  localparam int LAT   = 3;
  localparam int NIB   = DOTS / BUS_W;
  localparam int AW    = $clog2(2 * ROWS * NIB);
  localparam int LINE  = NIB * DIV + LAT;
  localparam int FRAME = ROWS * LINE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_rd;
  logic [AW-1:0] fb_addr_up, fb_addr_lo;
  logic [BUS_W-1:0] fb_data_up, fb_data_lo;
  logic lcd_cp2, lcd_cp1, lcd_s, lcd_m;
  logic [BUS_W-1:0] lcd_du, lcd_dl;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_dualscan_ctrl #(
    .DOTS(DOTS), .BUS_W(BUS_W), .ROWS(ROWS),
    .CP2_DIV(DIV), .LATCH_CYC(LAT), .CLK_KHZ(4)
  ) u_lcd_dualscan_ctrl (
    .clk(clk), .rst_n(rst_n), .fb_rd(fb_rd),
    .fb_addr_up(fb_addr_up), .fb_addr_lo(fb_addr_lo),
    .fb_data_up(fb_data_up), .fb_data_lo(fb_data_lo),
    .lcd_cp2(lcd_cp2), .lcd_cp1(lcd_cp1), .lcd_s(lcd_s), .lcd_m(lcd_m),
    .lcd_du(lcd_du), .lcd_dl(lcd_dl)
  );

  function automatic logic [3:0] pat(input int a);
    return 4'((a * 7 + 3) % 16);
  endfunction

  // framebuffer model: one-cycle read latency
  always_ff @(posedge clk) begin
    if (fb_rd) begin
      fb_data_up <= pat(int'(fb_addr_up));
      fb_data_lo <= pat(int'(fb_addr_lo));
    end
  end

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: expected nibble pairs, frame by frame, row by row, left to right
  task automatic push_frames(input int frames);
    for (int f = 0; f < frames; f++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < NIB; c++)
          exp_q.push_back({pat(r * NIB + c), pat((r + ROWS) * NIB + c)});
  endtask

  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  logic p_cp2 = 0, p_cp1 = 0, p_s = 0, p_m = 0;
  int line_nib = 0, b_row = 0, s_rises = 0, last_s = -1, m_toggles = 0;
  bit seen_cp1 = 0;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cp2 && !lcd_cp2) begin
        logic [7:0] e;
        if (exp_q.size() == 0) begin
          chk(0, "R3 R5 queue empty", 0, 1);
        end else begin
          e = exp_q.pop_front();
          chk({lcd_du, lcd_dl} == e, "R3 R5 nibble pair", {lcd_du, lcd_dl}, e);
        end
        line_nib++;
      end
      if (lcd_m != p_m) begin
        m_toggles++;
        chk(p_cp1 && !lcd_cp1 && b_row == ROWS - 1, "R7 polarity edge placement",
            b_row, ROWS - 1);
      end
      if (lcd_cp1) begin
        chk(!lcd_cp2, "R4 dot clock quiet in latch", lcd_cp2, 0);
        chk(lcd_s == (b_row == 0), "R6 scan start", lcd_s, b_row == 0);
      end
      if (lcd_cp1 && !p_cp1 && !seen_cp1) begin
        seen_cp1 = 1;
        chk(cyc == LAT + NIB * DIV, "R10 first row strobe cycle", cyc, LAT + NIB * DIV);
        chk(lcd_m == 0, "R10 polarity untouched by priming", lcd_m, 0);
      end
      if (p_cp1 && !lcd_cp1) begin
        chk(line_nib == NIB, "R2 pulses per row", line_nib, NIB);
        chk(lcd_cp2, "R4 next row starts at once", lcd_cp2, 1);
        line_nib = 0;
        b_row = (b_row + 1) % ROWS;
      end
      if (lcd_s && !p_s) begin
        if (last_s >= 0) begin
          chk(cyc - last_s == FRAME, "R9 frame period", cyc - last_s, FRAME);
          chk(m_toggles == 1, "R7 toggles per frame", m_toggles, 1);
        end
        m_toggles = 0;
        last_s = cyc;
        s_rises++;
      end
      if (fb_rd)
        chk(int'(fb_addr_lo) - int'(fb_addr_up) == ROWS * NIB &&
            int'(fb_addr_up) < ROWS * NIB, "R8 read addresses",
            int'(fb_addr_lo) - int'(fb_addr_up), ROWS * NIB);
      p_cp2 = lcd_cp2; p_cp1 = lcd_cp1; p_s = lcd_s; p_m = lcd_m;
    end
  end

  initial begin
    int n;
    push_frames(7);
    repeat (3) @(negedge clk);
    chk({lcd_cp2, lcd_cp1, lcd_s, lcd_m, lcd_du, lcd_dl} == '0, "R1 reset outputs",
        {lcd_cp2, lcd_cp1, lcd_s, lcd_m, lcd_du, lcd_dl}, 0);
    rst_n = 1'b1;
    n = 0;
    while (s_rises < 5 && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (n >= 5000) chk(0, "watchdog", n, 5000);
    @(negedge clk);
    chk(lcd_m == 0, "R7 polarity after even toggles", lcd_m, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule